// File: doc/BRIEF.md
# Transmit FIFO with Collision Retry

This block buffers outgoing frames between a DMA engine that writes 32-bit words and a MAC that reads them. Every stored word carries start and end markers plus a count of valid bytes in the final word. The FIFO can therefore find where each frame begins and where it ends.

While the opening bytes of a frame are still held, the MAC may ask for the frame again after a half-duplex collision. The read side then starts over at the first word of that frame. Once more than a set number of bytes of the frame has been read, the block gives up that option. The threshold is one value at normal rates and a larger value in the gigabit mode. From then on the storage the MAC has read is handed back to the writer.

Reading can wait for a whole frame to be stored (store-and-forward) or begin as soon as a word is present (cut-through). A self-clearing flush empties the buffer. Running out of data in the middle of a frame is reported as an underflow, and the rest of that frame is discarded. At the end of each frame, or when it is cut short, a status word goes back toward the DMA.

Top module: `tx_retry_fifo`

## Requirements
- R1: A `retry_i` pulse inside a frame, when at most the threshold number of bytes of that frame has been popped, rewinds reading. The next word presented is the frame's first word, with `rd_sof_o`=1 and its original data, and the retry count in that frame's status goes up by one.
- R2: The threshold is 96 bytes when `gig_i`=0 and 548 bytes when `gig_i`=1. A retry that arrives after the popped bytes of the frame exceed the threshold is ignored: reading continues with the next unread word. The frame's status then has `sts_late_o`=1 and a retry count that does not include it.
- R3: `free_words_o` equals DEPTH minus the words held since the committed read point. Words popped from a frame whose retry window is still open stay counted as used until the threshold is crossed or the frame's last word is popped. `wr_ready_o` is 0 whenever `free_words_o` is 0.
- R4: A one-cycle `flush_set_i` raises `flush_o` for exactly one cycle, starting on the next clock edge. During that cycle `rd_valid_o` and `wr_ready_o` are 0. Afterwards the FIFO is empty with `free_words_o`=DEPTH, and no status is issued for the abandoned frame.
- R5: With `saf_i`=1, `rd_valid_o` stays 0 for a new frame until its end word (`wr_eof_i`=1) has been written. With `saf_i`=0, a frame becomes readable on the cycle after its first word is written.
- R6: If `rd_ready_i`=1 inside a frame while no word is stored, `underflow_o` pulses for that cycle. A status word with `sts_underflow_o`=1 and the bytes popped so far follows, and the remaining words of that frame, up to its end word, are dropped without being presented.
- R7: After a frame's end word is popped, `sts_valid_o` rises on the next cycle and holds until `sts_ready_i` is sampled high. `sts_bytes_o` then equals 4*(words-1) + `wr_last_i`+1, where `wr_last_i` is the number of valid bytes in the end word minus one.
- R8: Words leave in the order written, with their data, start marker, end marker and last-byte field intact.
- R9: A `retry_i` pulse while no frame is being read has no effect on the next frame's data or retry count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| saf_i | input | 1 | 1 = store-and-forward, 0 = cut-through |
| gig_i | input | 1 | Selects the larger retry threshold |
| flush_set_i | input | 1 | Writes the flush bit |
| flush_o | output | 1 | Flush bit, self-clearing |
| wr_valid_i | input | 1 | Write word valid |
| wr_ready_o | output | 1 | Space available for a word |
| wr_data_i | input | 32 | Write data |
| wr_sof_i | input | 1 | First word of a frame |
| wr_eof_i | input | 1 | Last word of a frame |
| wr_last_i | input | 2 | Valid bytes in the last word minus one |
| free_words_o | output | 11 | Words the writer may still store |
| rd_valid_o | output | 1 | Word presented to the MAC |
| rd_ready_i | input | 1 | MAC pops the word |
| rd_data_o | output | 32 | Read data |
| rd_sof_o | output | 1 | First-word marker |
| rd_eof_o | output | 1 | Last-word marker |
| rd_last_o | output | 2 | Valid bytes in the last word minus one |
| retry_i | input | 1 | Collision retry request |
| underflow_o | output | 1 | Data ran out inside a frame |
| sts_valid_o | output | 1 | Status word valid |
| sts_ready_i | input | 1 | Status accepted |
| sts_bytes_o | output | 16 | Bytes sent in the final attempt |
| sts_underflow_o | output | 1 | Frame was cut short |
| sts_retries_o | output | 4 | Retries honoured, saturating |
| sts_late_o | output | 1 | A retry came after the threshold |

## Verification
A rewind pointer that is stale or wrong shows up on the first word read after a retry: that word lacks the start marker, or its data is not the frame's first value. A commit that comes too early or too late shows in `free_words_o` on the cycle after the pop that crosses the threshold. It also decides whether the next retry is honoured, which shows in the data stream and in the status late flag. A wrong frame-completion count shows in store-and-forward mode, where `rd_valid_o` rises before the end word arrives or never rises. A fault in the byte count or the underflow tracking appears in the status word issued one cycle after the frame ends.

// File: rtl/tx_retry_fifo_pkg.sv
package tx_retry_fifo_pkg;
  localparam int unsigned DW   = 32;
  localparam int unsigned BPW  = DW / 8;
  localparam int unsigned LB_W = $clog2(BPW);

  typedef struct packed {
    logic            sof;
    logic            eof;
    logic [LB_W-1:0] last;
    logic [DW-1:0]   data;
  } fifo_word_t;
endpackage

// File: rtl/tx_retry_fifo_mem.sv
module tx_retry_fifo_mem
  import tx_retry_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  fifo_word_t    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output fifo_word_t    rdata_o
);
  fifo_word_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tx_retry_fifo_rd.sv
module tx_retry_fifo_rd #(
  parameter int unsigned PW      = 11,
  parameter int unsigned LB_W    = 2,
  parameter int unsigned BPW     = 4,
  parameter int unsigned THR     = 96,
  parameter int unsigned THR_GIG = 548,
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned RET_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             saf_i,
  input  logic             gig_i,
  input  logic [PW-1:0]    wptr_i,
  input  logic             eof_nz_i,
  input  logic             word_eof_i,
  input  logic [LB_W-1:0]  word_last_i,
  input  logic             rd_ready_i,
  input  logic             retry_i,
  output logic [PW-1:0]    rptr_o,
  output logic [PW-1:0]    cptr_o,
  output logic             rd_valid_o,
  output logic             pop_o,
  output logic             underflow_o,
  output logic             rewind_o,
  output logic             late_evt_o,
  output logic             done_o,
  output logic [LEN_W-1:0] done_bytes_o,
  output logic [RET_W-1:0] done_retries_o,
  output logic             done_late_o
);
  logic [PW-1:0]    rptr_q, cptr_q, rptr_inc;
  logic             in_frame_q, drop_q, commit_q, late_q;
  logic [LEN_W-1:0] bytes_q, bytes_nx, add_bytes, thr;
  logic [RET_W-1:0] retries_q;
  logic             empty, retry_ok, pop_data, drop_pop, uf, commit_now;

  assign empty      = (rptr_q == wptr_i);
  assign rd_valid_o = ~clr_i & ~empty & ~drop_q & (in_frame_q | ~saf_i | eof_nz_i);
  assign retry_ok   = ~clr_i & retry_i & in_frame_q & ~commit_q;
  assign late_evt_o = ~clr_i & retry_i & in_frame_q & commit_q;
  assign pop_data   = rd_valid_o & rd_ready_i & ~retry_ok;
  assign drop_pop   = ~clr_i & drop_q & ~empty;
  assign uf         = ~clr_i & in_frame_q & rd_ready_i & empty & ~retry_ok;
  assign pop_o      = pop_data | drop_pop;
  assign rewind_o   = retry_ok;
  assign underflow_o = uf;

  assign add_bytes  = word_eof_i ? LEN_W'(word_last_i) + LEN_W'(1) : LEN_W'(BPW);
  assign bytes_nx   = bytes_q + add_bytes;
  assign thr        = gig_i ? LEN_W'(THR_GIG) : LEN_W'(THR);
  assign commit_now = (bytes_nx > thr);
  assign rptr_inc   = rptr_q + PW'(1);

  assign done_o         = (pop_data & word_eof_i) | uf;
  assign done_bytes_o   = uf ? bytes_q : bytes_nx;
  assign done_retries_o = in_frame_q ? retries_q : '0;
  assign done_late_o    = in_frame_q & (late_q | late_evt_o);
  assign rptr_o         = rptr_q;
  assign cptr_o         = cptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q <= '0; cptr_q <= '0; in_frame_q <= 1'b0; drop_q <= 1'b0;
      commit_q <= 1'b0; late_q <= 1'b0; bytes_q <= '0; retries_q <= '0;
    end else if (clr_i) begin
      rptr_q <= '0; cptr_q <= '0; in_frame_q <= 1'b0; drop_q <= 1'b0;
      commit_q <= 1'b0; late_q <= 1'b0; bytes_q <= '0; retries_q <= '0;
    end else begin
      if (late_evt_o) late_q <= 1'b1;
      if (retry_ok) begin
        rptr_q  <= cptr_q;
        bytes_q <= '0;
        if (retries_q != '1) retries_q <= retries_q + RET_W'(1);
      end else if (uf) begin
        in_frame_q <= 1'b0;
        drop_q     <= 1'b1;
        commit_q   <= 1'b0;
        bytes_q    <= '0;
        cptr_q     <= rptr_q;
      end else if (pop_data) begin
        rptr_q <= rptr_inc;
        if (!in_frame_q) begin
          retries_q <= '0;
          late_q    <= 1'b0;
        end
        if (word_eof_i) begin
          in_frame_q <= 1'b0;
          commit_q   <= 1'b0;
          bytes_q    <= '0;
          cptr_q     <= rptr_inc;
        end else begin
          in_frame_q <= 1'b1;
          bytes_q    <= bytes_nx;
          // past the threshold the read point is final
          if (commit_q || commit_now) begin
            commit_q <= 1'b1;
            cptr_q   <= rptr_inc;
          end
        end
      end else if (drop_pop) begin
        rptr_q <= rptr_inc;
        cptr_q <= rptr_inc;
        if (word_eof_i) drop_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tx_retry_fifo_sts.sv
module tx_retry_fifo_sts #(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned RET_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic [LEN_W-1:0] bytes_i,
  input  logic             uf_i,
  input  logic [RET_W-1:0] retries_i,
  input  logic             late_i,
  input  logic             sts_ready_i,
  output logic             sts_valid_o,
  output logic [LEN_W-1:0] sts_bytes_o,
  output logic             sts_underflow_o,
  output logic [RET_W-1:0] sts_retries_o,
  output logic             sts_late_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_valid_o     <= 1'b0;
      sts_bytes_o     <= '0;
      sts_underflow_o <= 1'b0;
      sts_retries_o   <= '0;
      sts_late_o      <= 1'b0;
    end else if (done_i) begin
      sts_valid_o     <= 1'b1;
      sts_bytes_o     <= bytes_i;
      sts_underflow_o <= uf_i;
      sts_retries_o   <= retries_i;
      sts_late_o      <= late_i;
    end else if (sts_valid_o && sts_ready_i) begin
      sts_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tx_retry_fifo.sv
module tx_retry_fifo
  import tx_retry_fifo_pkg::*;
#(
  parameter int unsigned DEPTH         = 1024,
  parameter int unsigned THR_BYTES     = 96,
  parameter int unsigned THR_BYTES_GIG = 548,
  parameter int unsigned LEN_W         = 16,
  parameter int unsigned RET_W         = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             saf_i,
  input  logic             gig_i,
  input  logic             flush_set_i,
  output logic             flush_o,
  input  logic             wr_valid_i,
  output logic             wr_ready_o,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             wr_sof_i,
  input  logic             wr_eof_i,
  input  logic [LB_W-1:0]  wr_last_i,
  output logic [$clog2(DEPTH):0] free_words_o,
  output logic             rd_valid_o,
  input  logic             rd_ready_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             rd_sof_o,
  output logic             rd_eof_o,
  output logic [LB_W-1:0]  rd_last_o,
  input  logic             retry_i,
  output logic             underflow_o,
  output logic             sts_valid_o,
  input  logic             sts_ready_i,
  output logic [LEN_W-1:0] sts_bytes_o,
  output logic             sts_underflow_o,
  output logic [RET_W-1:0] sts_retries_o,
  output logic             sts_late_o
);
  // DEPTH must be a power of two for pointer wrap
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic             flush_q;
  logic [PW-1:0]    wptr_q, rptr, cptr, used, eof_cnt_q;
  logic             we, pop, rewind, late_evt, eof_nz, done, done_late;
  logic [LEN_W-1:0] done_bytes;
  logic [RET_W-1:0] done_retries;
  fifo_word_t       wr_word, rd_word;

  assign flush_o      = flush_q;
  assign used         = wptr_q - cptr;
  assign free_words_o = PW'(DEPTH) - used;
  assign wr_ready_o   = ~flush_q & (used != PW'(DEPTH));
  assign we           = wr_valid_i & wr_ready_o;
  assign eof_nz       = (eof_cnt_q != '0);

  assign wr_word.sof  = wr_sof_i;
  assign wr_word.eof  = wr_eof_i;
  assign wr_word.last = wr_last_i;
  assign wr_word.data = wr_data_i;

  assign rd_data_o = rd_word.data;
  assign rd_sof_o  = rd_word.sof;
  assign rd_eof_o  = rd_word.eof;
  assign rd_last_o = rd_word.last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_q   <= 1'b0;
      wptr_q    <= '0;
      eof_cnt_q <= '0;
    end else begin
      flush_q <= flush_set_i;
      if (flush_q) begin
        wptr_q    <= '0;
        eof_cnt_q <= '0;
      end else begin
        if (we) wptr_q <= wptr_q + PW'(1);
        case ({we & wr_eof_i, pop & rd_word.eof})
          2'b10:   eof_cnt_q <= eof_cnt_q + PW'(1);
          2'b01:   eof_cnt_q <= eof_cnt_q - PW'(1);
          default: eof_cnt_q <= eof_cnt_q;
        endcase
      end
    end
  end

  tx_retry_fifo_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (we),
    .waddr_i (wptr_q[AW-1:0]),
    .wdata_i (wr_word),
    .raddr_i (rptr[AW-1:0]),
    .rdata_o (rd_word)
  );

  tx_retry_fifo_rd #(
    .PW(PW), .LB_W(LB_W), .BPW(BPW), .THR(THR_BYTES), .THR_GIG(THR_BYTES_GIG),
    .LEN_W(LEN_W), .RET_W(RET_W)
  ) u_rd (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .clr_i          (flush_q),
    .saf_i          (saf_i),
    .gig_i          (gig_i),
    .wptr_i         (wptr_q),
    .eof_nz_i       (eof_nz),
    .word_eof_i     (rd_word.eof),
    .word_last_i    (rd_word.last),
    .rd_ready_i     (rd_ready_i),
    .retry_i        (retry_i),
    .rptr_o         (rptr),
    .cptr_o         (cptr),
    .rd_valid_o     (rd_valid_o),
    .pop_o          (pop),
    .underflow_o    (underflow_o),
    .rewind_o       (rewind),
    .late_evt_o     (late_evt),
    .done_o         (done),
    .done_bytes_o   (done_bytes),
    .done_retries_o (done_retries),
    .done_late_o    (done_late)
  );

  tx_retry_fifo_sts #(.LEN_W(LEN_W), .RET_W(RET_W)) u_sts (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .done_i          (done),
    .bytes_i         (done_bytes),
    .uf_i            (underflow_o),
    .retries_i       (done_retries),
    .late_i          (done_late),
    .sts_ready_i     (sts_ready_i),
    .sts_valid_o     (sts_valid_o),
    .sts_bytes_o     (sts_bytes_o),
    .sts_underflow_o (sts_underflow_o),
    .sts_retries_o   (sts_retries_o),
    .sts_late_o      (sts_late_o)
  );
endmodule

// File: rtl/tx_retry_fifo_chk.sv
module tx_retry_fifo_chk #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned PW    = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          saf_i,
  input logic          flush_set_i,
  input logic          flush_o,
  input logic          wr_ready_o,
  input logic [PW-1:0] free_words_o,
  input logic          rd_valid_o,
  input logic          rd_ready_i,
  input logic          rd_sof_o,
  input logic          underflow_o,
  input logic          sts_valid_o,
  input logic          sts_ready_i,
  input logic          sts_underflow_o,
  input logic          rewind_i,
  input logic          late_evt_i,
  input logic          eof_nz_i
);
  AST_REWIND_SOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rewind_i |=> (!rd_valid_o || rd_sof_o)); // R1
  AST_LATE_NO_REWIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (late_evt_i && !rd_ready_i) |=> !(rd_valid_o && rd_sof_o)); // R2
  AST_FREE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_words_o <= PW'(DEPTH)); // R3
  AST_FULL_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_words_o == '0) |-> !wr_ready_o); // R3
  AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_o && !flush_set_i) |=> !flush_o); // R4
  AST_FLUSH_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (!rd_valid_o && !wr_ready_o)); // R4
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> (free_words_o == PW'(DEPTH))); // R4
  AST_SAF_WHOLE_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (saf_i && rd_valid_o && rd_sof_o) |-> eof_nz_i); // R5
  AST_UNDERFLOW_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> (rd_ready_i && !rd_valid_o)); // R6
  AST_UNDERFLOW_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> (sts_valid_o && sts_underflow_o)); // R6
  AST_STATUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_valid_o && !sts_ready_i) |=> sts_valid_o); // R7
endmodule

bind tx_retry_fifo tx_retry_fifo_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .saf_i           (saf_i),
  .flush_set_i     (flush_set_i),
  .flush_o         (flush_o),
  .wr_ready_o      (wr_ready_o),
  .free_words_o    (free_words_o),
  .rd_valid_o      (rd_valid_o),
  .rd_ready_i      (rd_ready_i),
  .rd_sof_o        (rd_sof_o),
  .underflow_o     (underflow_o),
  .sts_valid_o     (sts_valid_o),
  .sts_ready_i     (sts_ready_i),
  .sts_underflow_o (sts_underflow_o),
  .rewind_i        (rewind),
  .late_evt_i      (late_evt),
  .eof_nz_i        (eof_nz)
);

// File: tb/tx_retry_fifo_bench.sv
module tx_retry_fifo_bench;
  localparam int DEPTH = 1024;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic saf_i = 1'b0, gig_i = 1'b0, flush_set_i = 1'b0;
  logic wr_valid_i = 1'b0, wr_sof_i = 1'b0, wr_eof_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [1:0]  wr_last_i = '0;
  logic rd_ready_i = 1'b0, retry_i = 1'b0, sts_ready_i = 1'b0;
  logic flush_o, wr_ready_o, rd_valid_o, rd_sof_o, rd_eof_o, underflow_o;
  logic sts_valid_o, sts_underflow_o, sts_late_o;
  logic [10:0] free_words_o;
  logic [31:0] rd_data_o;
  logic [1:0]  rd_last_o;
  logic [15:0] sts_bytes_o;
  logic [3:0]  sts_retries_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  tx_retry_fifo u_tx_retry_fifo (
    .clk_i(clk), .rst_ni(rst_ni), .saf_i(saf_i), .gig_i(gig_i),
    .flush_set_i(flush_set_i), .flush_o(flush_o),
    .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o), .wr_data_i(wr_data_i),
    .wr_sof_i(wr_sof_i), .wr_eof_i(wr_eof_i), .wr_last_i(wr_last_i),
    .free_words_o(free_words_o),
    .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i), .rd_data_o(rd_data_o),
    .rd_sof_o(rd_sof_o), .rd_eof_o(rd_eof_o), .rd_last_o(rd_last_o),
    .retry_i(retry_i), .underflow_o(underflow_o),
    .sts_valid_o(sts_valid_o), .sts_ready_i(sts_ready_i), .sts_bytes_o(sts_bytes_o),
    .sts_underflow_o(sts_underflow_o), .sts_retries_o(sts_retries_o), .sts_late_o(sts_late_o)
  );

  // columns: words, last, retry_at_word (-1 none), gig, saf, exp_retries, exp_late
  localparam int TBL [6][7] = '{
    '{  4, 3,  -1, 0, 0, 0, 0},
    '{ 30, 1,  24, 0, 0, 1, 0},
    '{ 30, 0,  25, 0, 1, 0, 1},
    '{140, 2, 137, 1, 0, 1, 0},
    '{140, 3, 138, 1, 1, 0, 1},
    '{  3, 0,   1, 0, 1, 1, 0}
  };

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr_word(input logic [31:0] d, input bit sof, input bit eof, input int last);
    @(negedge clk);
    wr_valid_i = 1'b1; wr_data_i = d; wr_sof_i = sof; wr_eof_i = eof; wr_last_i = 2'(last);
    @(posedge clk);
    #1 wr_valid_i = 1'b0; wr_sof_i = 1'b0; wr_eof_i = 1'b0;
  endtask

  task automatic wr_frame(input int n, input int last, input logic [31:0] base);
    for (int i = 0; i < n; i++) wr_word(base + 32'(i), i == 0, i == n - 1, last);
  endtask

  task automatic pop_one();
    @(negedge clk);
    rd_ready_i = 1'b1;
    @(posedge clk);
    #1 rd_ready_i = 1'b0;
  endtask

  task automatic rd_frame(input int n, input int last, input logic [31:0] base,
                          input int k, input bit late);
    int idx = 0;
    bit done = 0;
    bit retried = 0;
    while (!done) begin
      @(negedge clk);
      rd_ready_i = 1'b0;
      if (k >= 0 && !retried && idx == k) begin
        retry_i = 1'b1; retried = 1;
        @(negedge clk);
        retry_i = 1'b0;
        if (!late) idx = 0;
        if (!late) chk("R1 sof after rewind", rd_sof_o, 1);
        else       chk("R2 late retry keeps position", rd_data_o, base + 32'(idx));
      end
      if (rd_valid_o) begin
        chk("R8 data order", rd_data_o, base + 32'(idx));
        chk("R8 sof marker", rd_sof_o, idx == 0);
        if (rd_eof_o) begin
          done = 1;
          chk("R8 eof position", idx, n - 1);
          chk("R8 last field", rd_last_o, last);
        end
        rd_ready_i = 1'b1;
        @(posedge clk);
        idx++;
      end
    end
    @(negedge clk);
    rd_ready_i = 1'b0;
  endtask

  task automatic chk_sts(input string req, input int bytes, input bit uf, input int ret, input bit late);
    @(negedge clk);
    chk({req, " sts_valid"}, sts_valid_o, 1);
    chk({req, " sts_bytes"}, sts_bytes_o, bytes);
    chk({req, " sts_underflow"}, sts_underflow_o, uf);
    chk({req, " sts_retries"}, sts_retries_o, ret);
    chk({req, " sts_late"}, sts_late_o, late);
    sts_ready_i = 1'b1;
    @(negedge clk);
    sts_ready_i = 1'b0;
    chk("R7 status released", sts_valid_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: act=%0d exp=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // reset state
    chk("R4 reset free", free_words_o, DEPTH);
    chk("R4 reset rd_valid", rd_valid_o, 0);
    chk("R4 reset wr_ready", wr_ready_o, 1);
    chk("R4 reset flush", flush_o, 0);
    chk("R7 reset sts_valid", sts_valid_o, 0);

    // R9: retry with no frame in flight
    retry_i = 1'b1;
    @(negedge clk);
    retry_i = 1'b0;

    // vector table: R1 R2 R5 R7 R8 thresholds
    for (int r = 0; r < 6; r++) begin
      logic [31:0] base;
      base = 32'h1000 * 32'(r + 1);
      gig_i = TBL[r][3][0];
      saf_i = TBL[r][4][0];
      wr_frame(TBL[r][0], TBL[r][1], base);
      rd_frame(TBL[r][0], TBL[r][1], base, TBL[r][2], TBL[r][6] != 0);
      chk_sts(r == 0 ? "R9" : "R7", (TBL[r][0] - 1) * 4 + TBL[r][1] + 1, 0,
              TBL[r][5], TBL[r][6] != 0);
    end
    gig_i = 1'b0;

    // R3: free space tracks committed pointer
    saf_i = 1'b0;
    wr_frame(30, 3, 32'h8000);
    @(negedge clk);
    chk("R3 free after write", free_words_o, DEPTH - 30);
    for (int i = 0; i < 24; i++) pop_one();
    @(negedge clk);
    chk("R3 not freed inside window", free_words_o, DEPTH - 30);
    pop_one();
    @(negedge clk);
    chk("R3 freed at commit", free_words_o, DEPTH - 5);
    for (int i = 0; i < 5; i++) pop_one();
    @(negedge clk);
    chk("R3 freed at frame end", free_words_o, DEPTH);
    chk_sts("R7", 120, 0, 0, 0);

    // R5: store-and-forward waits for end word
    saf_i = 1'b1;
    for (int i = 0; i < 3; i++) wr_word(32'h9000 + 32'(i), i == 0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R5 saf holds partial frame", rd_valid_o, 0);
    wr_word(32'h9003, 0, 0, 0);
    wr_word(32'h9004, 0, 1, 1);
    @(negedge clk);
    chk("R5 saf releases whole frame", rd_valid_o, 1);
    rd_frame(5, 1, 32'h9000, -1, 0);
    chk_sts("R5", 18, 0, 0, 0);

    // R5 cut-through, then R6 underflow
    saf_i = 1'b0;
    wr_word(32'hA000, 1, 0, 0);
    @(negedge clk);
    chk("R5 cut-through readable", rd_valid_o, 1);
    wr_word(32'hA001, 0, 0, 0);
    pop_one();
    pop_one();
    @(negedge clk);
    rd_ready_i = 1'b1;
    #1 chk("R6 underflow pulse", underflow_o, 1);
    @(posedge clk);
    #1 rd_ready_i = 1'b0;
    chk_sts("R6", 8, 1, 0, 0);
    wr_word(32'hA002, 0, 0, 0);
    wr_word(32'hA003, 0, 1, 3);
    repeat (3) @(negedge clk);
    chk("R6 rest of frame dropped", rd_valid_o, 0);
    chk("R6 storage returned", free_words_o, DEPTH);

    // R4: flush mid-frame
    wr_frame(5, 3, 32'hB000);
    pop_one();
    pop_one();
    @(negedge clk);
    flush_set_i = 1'b1;
    @(posedge clk);
    #1 flush_set_i = 1'b0;
    @(negedge clk);
    chk("R4 flush bit set", flush_o, 1);
    chk("R4 read stopped", rd_valid_o, 0);
    chk("R4 write blocked", wr_ready_o, 0);
    @(negedge clk);
    chk("R4 flush self-clears", flush_o, 0);
    chk("R4 empty after flush", free_words_o, DEPTH);
    chk("R4 nothing readable", rd_valid_o, 0);
    chk("R4 no status", sts_valid_o, 0);
    wr_frame(2, 0, 32'hC000);
    rd_frame(2, 0, 32'hC000, -1, 0);
    chk_sts("R4", 5, 0, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule